// File: doc/BRIEF.md
# Compressed Branch Target Buffer

This block predicts the next fetch address from the current fetch address. It is a two-way set-associative table. Each way keeps a valid flag, a short partial tag and only the low-order bits of a taken branch's destination. A lookup reads one set, compares the partial tag in both ways and, on a match, builds the full destination. The upper bits of that destination come from the fetch address and the low bits come from the stored field. When no way matches, the prediction is the sequential address, the fetch address plus four.

Resolved taken branches are written through a separate update port. Only the address bits that the table actually keeps are presented on that port. An update whose tag already sits in the set rewrites that way. Otherwise it fills an empty way first, and when both ways are full it replaces the way that a one-bit-per-set recency flag marks as least recently used. Lookups that hit refresh that flag.

Because tags are partial and targets are truncated, two branches can share an entry, and a far target comes out wrong. The rest of the pipeline detects and repairs these wrong predictions.

Top module: `cbtb_top`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses until an update writes an entry.
- R2: On a miss, `hit_o` is 0 and `next_pc_o` equals `fetch_pc_i + 4` modulo 2^32.
- R3: A lookup hits when a valid way in set `fetch_pc_i[5:2]` holds the partial tag `fetch_pc_i[9:6]`. On a hit, `next_pc_o` is `{fetch_pc_i[31:24], stored[23:0]}`.
- R4: Two fetch addresses that agree in bits [9:2] map to the same entry and receive the same stored low target bits.
- R5: An update becomes visible to lookups from the cycle after it is presented. A lookup in the same cycle still sees the old contents.
- R6: An update whose partial tag matches a valid way of its set rewrites that way, and the newest target is returned.
- R7: An update with no matching way writes the lowest-numbered invalid way. If the set is full, it writes the way marked least recently used.
- R8: A lookup hit makes the hit way most recently used. An update makes the written way most recently used and takes priority over a hit to the same set in the same cycle.
- R9: The two ways of a set hold two distinct branches at once, and each returns its own target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fetch_pc_i | input | 32 | Current fetch address |
| next_pc_o | output | 32 | Predicted next fetch address |
| hit_o | output | 1 | Lookup matched a valid way |
| upd_en_i | input | 1 | Write a resolved taken branch |
| upd_pc_i | input | 8 | Branch address bits [9:2] (set index and partial tag) |
| upd_target_i | input | 24 | Low 24 bits of the branch destination |

## Verification
The bench uses the default geometry: 16 sets, 2 ways, a 4-bit partial tag and a 24-bit stored target in a 32-bit address. A small tag makes aliasing easy to reach: addresses that differ only above bit 9 share an entry. The 24-bit target field makes far destinations easy to reach, because a target whose bits [31:24] differ from those of the fetch address is predicted with the fetch address's upper byte. With only two ways, a few updates to one set fill it and force eviction, so the replacement order and the effect of lookup hits on recency are checked directly.

// File: rtl/cbtb_pkg.sv
package cbtb_pkg;
  parameter int unsigned PC_W      = 32;
  parameter int unsigned ALIGN_W   = 2;
  parameter int unsigned IDX_W     = 4;
  parameter int unsigned TAG_W     = 4;
  parameter int unsigned TGT_W     = 24;
  parameter int unsigned WAYS      = 2;
  localparam int unsigned SETS     = 1 << IDX_W;
  localparam int unsigned WAY_W    = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int unsigned KEY_HI   = ALIGN_W + IDX_W + TAG_W;
  localparam int unsigned INST_B   = 1 << ALIGN_W;

  typedef struct packed {
    logic             valid;
    logic [TAG_W-1:0] tag;
    logic [TGT_W-1:0] tgt;
  } entry_t;
endpackage

// File: rtl/cbtb_tag_match.sv
module cbtb_tag_match
  import cbtb_pkg::*;
(
  input  entry_t           set_i [WAYS],
  input  logic [TAG_W-1:0] tag_i,
  output logic [WAYS-1:0]  hit_vec_o,
  output logic             hit_o,
  output logic [WAY_W-1:0] way_o
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec_o[w] = set_i[w].valid && (set_i[w].tag == tag_i);
  end

  assign hit_o = |hit_vec_o;

  // lowest matching way wins
  always_comb begin
    way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec_o[w]) way_o = WAY_W'(w);
    end
  end
endmodule

// File: rtl/cbtb_victim.sv
module cbtb_victim
  import cbtb_pkg::*;
(
  input  logic [WAYS-1:0]  valid_i,
  input  logic             lru_i,
  input  logic             match_i,
  input  logic [WAY_W-1:0] match_way_i,
  output logic [WAY_W-1:0] way_o
);
  logic             any_free;
  logic [WAY_W-1:0] free_way;

  assign any_free = ~&valid_i;

  always_comb begin
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_i[w]) free_way = WAY_W'(w);
    end
  end

  always_comb begin
    if (match_i)       way_o = match_way_i;
    else if (any_free) way_o = free_way;
    else               way_o = WAY_W'(lru_i);
  end
endmodule

// File: rtl/cbtb_store.sv
module cbtb_store
  import cbtb_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] lk_idx_i,
  input  logic             lk_hit_i,
  input  logic [WAY_W-1:0] lk_way_i,
  output entry_t           lk_set_o [WAYS],
  input  logic             upd_en_i,
  input  logic [IDX_W-1:0] upd_idx_i,
  input  logic [WAY_W-1:0] upd_way_i,
  input  logic [TAG_W-1:0] upd_tag_i,
  input  logic [TGT_W-1:0] upd_tgt_i,
  output entry_t           upd_set_o [WAYS],
  output logic             upd_lru_o
);
  entry_t           mem [SETS][WAYS];
  logic [SETS-1:0]  lru;  // per set: way to evict next
  logic [SETS*WAYS-1:0] valid_flat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) mem[s][w] <= '0;
    end else if (upd_en_i) begin
      mem[upd_idx_i][upd_way_i] <= '{valid: 1'b1, tag: upd_tag_i, tgt: upd_tgt_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lru <= '0;
    end else begin
      if (lk_hit_i && !(upd_en_i && upd_idx_i == lk_idx_i))
        lru[lk_idx_i] <= ~lk_way_i[0];
      if (upd_en_i)
        lru[upd_idx_i] <= ~upd_way_i[0];
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_rd
    assign lk_set_o[w]  = mem[lk_idx_i][w];
    assign upd_set_o[w] = mem[upd_idx_i][w];
  end
  assign upd_lru_o = lru[upd_idx_i];

  for (genvar s = 0; s < SETS; s++) begin : g_vs
    for (genvar w = 0; w < WAYS; w++) begin : g_vw
      assign valid_flat[s*WAYS+w] = mem[s][w].valid;
    end
  end

  // R5
  no_silent_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_en_i |=> $stable(valid_flat));
  // R1
  one_fill_per_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(valid_flat) <= $past($countones(valid_flat)) + 1);
  // R8
  hit_makes_mru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_hit_i && !upd_en_i) |=> lru[$past(lk_idx_i)] != $past(lk_way_i[0]));
  // R8
  write_makes_mru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_en_i |=> lru[$past(upd_idx_i)] != $past(upd_way_i[0]));
endmodule

// File: rtl/cbtb_top.sv
module cbtb_top
  import cbtb_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [PC_W-1:0]       fetch_pc_i,
  output logic [PC_W-1:0]       next_pc_o,
  output logic                  hit_o,
  input  logic                  upd_en_i,
  input  logic [KEY_HI-1:ALIGN_W] upd_pc_i,
  input  logic [TGT_W-1:0]      upd_target_i
);
  logic [IDX_W-1:0] lk_idx, upd_idx;
  logic [TAG_W-1:0] lk_tag, upd_tag;
  entry_t           lk_set  [WAYS];
  entry_t           upd_set [WAYS];
  logic [WAYS-1:0]  lk_vec, upd_vec, upd_valid;
  logic             lk_hit, upd_match, upd_lru;
  logic [WAY_W-1:0] lk_way, upd_match_way, upd_way;

  assign lk_idx  = fetch_pc_i[ALIGN_W +: IDX_W];
  assign lk_tag  = fetch_pc_i[ALIGN_W+IDX_W +: TAG_W];
  assign upd_idx = upd_pc_i[ALIGN_W +: IDX_W];
  assign upd_tag = upd_pc_i[ALIGN_W+IDX_W +: TAG_W];

  cbtb_store u_store (
    .clk_i, .rst_ni,
    .lk_idx_i  (lk_idx),
    .lk_hit_i  (lk_hit),
    .lk_way_i  (lk_way),
    .lk_set_o  (lk_set),
    .upd_en_i,
    .upd_idx_i (upd_idx),
    .upd_way_i (upd_way),
    .upd_tag_i (upd_tag),
    .upd_tgt_i (upd_target_i),
    .upd_set_o (upd_set),
    .upd_lru_o (upd_lru)
  );

  cbtb_tag_match u_lk_match (
    .set_i (lk_set), .tag_i (lk_tag),
    .hit_vec_o (lk_vec), .hit_o (lk_hit), .way_o (lk_way)
  );

  cbtb_tag_match u_upd_match (
    .set_i (upd_set), .tag_i (upd_tag),
    .hit_vec_o (upd_vec), .hit_o (upd_match), .way_o (upd_match_way)
  );

  for (genvar w = 0; w < WAYS; w++) begin : g_uv
    assign upd_valid[w] = upd_set[w].valid;
  end

  cbtb_victim u_victim (
    .valid_i (upd_valid), .lru_i (upd_lru),
    .match_i (upd_match), .match_way_i (upd_match_way),
    .way_o (upd_way)
  );

  // rebuild full target: upper bits borrowed from the fetch address
  always_comb begin
    if (lk_hit) next_pc_o = {fetch_pc_i[PC_W-1:TGT_W], lk_set[lk_way].tgt};
    else        next_pc_o = fetch_pc_i + PC_W'(INST_B);
  end
  assign hit_o = lk_hit;

  // R6
  single_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lk_vec) && $onehot0(upd_vec));
  // R7
  fill_free_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i && !upd_match && !(&upd_valid)) |-> !upd_valid[upd_way]);
  // R3
  upper_from_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> next_pc_o[PC_W-1:TGT_W] == fetch_pc_i[PC_W-1:TGT_W]);
  // R2
  miss_sequential_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> next_pc_o == fetch_pc_i + PC_W'(INST_B));
endmodule

// File: tb/sim_cbtb_top.sv
module sim_cbtb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic [31:0] next_pc;
  logic        hit;
  logic        upd_en = 1'b0;
  logic [9:2]  upd_pc = '0;
  logic [23:0] upd_tgt = '0;
  int n_chk = 0, n_fail = 0;
  localparam logic [31:0] IDLE = 32'h0;  // set 0 never written

  always #5 clk = ~clk;

  cbtb_top u0 (
    .clk_i (clk), .rst_ni (rst_n), .fetch_pc_i (fetch_pc),
    .next_pc_o (next_pc), .hit_o (hit),
    .upd_en_i (upd_en), .upd_pc_i (upd_pc), .upd_target_i (upd_tgt)
  );

  task automatic chk(string req, logic exp_hit, logic [31:0] exp_pc);
    n_chk++;
    if (hit !== exp_hit || next_pc !== exp_pc) begin
      n_fail++;
      $display("FAIL %s pc=%h: hit=%b next=%h expected hit=%b next=%h",
               req, fetch_pc, hit, next_pc, exp_hit, exp_pc);
    end
  endtask

  task automatic wr(logic [31:0] pc, logic [31:0] tgt);
    @(negedge clk);
    upd_en = 1'b1; upd_pc = pc[9:2]; upd_tgt = tgt[23:0]; fetch_pc = IDLE;
    @(negedge clk);
    upd_en = 1'b0;
  endtask

  // drive, check, then hold across one edge so a hit refreshes recency
  task automatic look(string req, logic [31:0] pc, logic exp_hit, logic [31:0] exp_pc);
    @(negedge clk);
    fetch_pc = pc;
    #1 chk(req, exp_hit, exp_pc);
  endtask

  function automatic logic [31:0] rebuild(logic [31:0] pc, logic [31:0] tgt);
    return {pc[31:24], tgt[23:0]};
  endfunction

  task automatic t_reset;
    look("R1", 32'h0000_1010, 1'b0, 32'h0000_1014);
    look("R1", 32'h4000_0024, 1'b0, 32'h4000_0028);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    upd_en = 1'b1; upd_pc = 8'h0C; upd_tgt = 24'h55AA00; fetch_pc = 32'h7700_0030;
    #1 chk("R5", 1'b0, 32'h7700_0034);
    @(negedge clk);
    upd_en = 1'b0;
    #1 chk("R5", 1'b1, 32'h7755_AA00);
  endtask

  task automatic t_far_alias;
    wr(32'h4000_0024, 32'h1234_5678);
    look("R3", 32'h4000_0024, 1'b1, 32'h4034_5678);
    look("R4", 32'hBEEF_FC24, 1'b1, 32'hBE34_5678);
  endtask

  task automatic t_overwrite;
    wr(32'h0000_2020, 32'h0011_1100);
    wr(32'h0000_2020, 32'h0022_2200);
    look("R6", 32'h0000_2020, 1'b1, 32'h0022_2200);
    wr(32'h0000_2060, 32'h0033_3300);
    look("R9", 32'h0000_2060, 1'b1, 32'h0033_3300);
    look("R6", 32'h0000_2020, 1'b1, 32'h0022_2200);
  endtask

  task automatic t_replace;
    wr(32'h0000_1010, 32'h00A0_A000);  // way0
    wr(32'h0000_1050, 32'h00C0_C000);  // way1
    look("R9", 32'h0000_1050, 1'b1, 32'h00C0_C000);
    look("R9", 32'h0000_1010, 1'b1, 32'h00A0_A000);  // way1 now LRU
    wr(32'h0000_1090, 32'h00D0_D000);  // R7 evicts the 1050 branch
    look("R7", 32'h0000_1050, 1'b0, 32'h0000_1054);
    look("R8", 32'h0000_1010, 1'b1, 32'h00A0_A000);
    look("R7", 32'h0000_1090, 1'b1, 32'h00D0_D000);  // way0 now LRU
    wr(32'h0000_10D0, 32'h00E0_E000);
    look("R8", 32'h0000_1010, 1'b0, 32'h0000_1014);
    look("R8", 32'h0000_1090, 1'b1, 32'h00D0_D000);
    look("R7", 32'h0000_10D0, 1'b1, rebuild(32'h0000_10D0, 32'h00E0_E000));
  endtask

  task automatic t_wrap;
    look("R2", 32'hFFFF_FFFC, 1'b0, 32'h0000_0000);
    look("R2", 32'h1234_5678, 1'b0, 32'h1234_567C);
  endtask

  task automatic t_reset_clear;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    look("R1", 32'h0000_2020, 1'b0, 32'h0000_2024);
    look("R1", 32'h0000_1090, 1'b0, 32'h0000_1094);
  endtask

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_same_cycle();
    t_far_alias();
    t_overwrite();
    t_replace();
    t_wrap();
    t_reset_clear();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule